// File: doc/BRIEF.md
# Super I/O Configuration Register Port

This block is the configuration front end of a legacy peripheral cluster. Software reaches it through a pair of byte-wide locations on a small I/O bus: the even location holds a pointer that picks one of three configuration bytes, and the odd location reads or writes the byte the pointer picks. The three bytes are a function-enable byte, a function-address byte and a power/test byte. They are driven out continuously so that a separate resource decoder can place the peripherals on the bus.

The reset contents of the three bytes come from a 5-bit strap, looked up in built-in tables, so a board sets its power-on arrangement without software. Reading the pointer location right after reset first gives a two-byte identification pattern and only then the pointer value. Writing the pointer ends that pattern at once.

A write to any of the three bytes raises a one-cycle notification pulse so that the decoder can re-evaluate. Setting a lock bit in the power/test byte freezes all three bytes until the next reset.

Top module: `sioCfgPort`

## Requirements
- R1: The port pair occupies two addresses starting at parameter BASE_ADDR (default 0x398). An access whose address bits above bit 0 differ from BASE_ADDR has no effect and reads as 0x00. Address bit 0 low selects the pointer location, high selects the data location.
- R2: Pointer values 0, 1 and 2 select the enable byte (`enableReg`), the address byte (`addrReg`) and the power/test byte (`powerReg`). A data write updates the selected byte at the clock edge, and a data read returns it combinationally while `busRd` is high.
- R3: A data write while the pointer is 3 or more changes no byte and gives no pulse. A data read with such a pointer returns 0x00.
- R4: Reset sets the pointer to 0 and restarts the identification pattern. It loads the three bytes from tables indexed by `strap`: strap 1 gives enable 0x4F, address 0x11, power/test 0x00; strap 31 gives enable 0x00, address 0x10, power/test 0x02.
- R5: After reset, the first pointer-location read returns 0x88, the second returns 0x00, and each later one returns the full 8-bit pointer value.
- R6: A pointer-location write stores the full byte as the pointer and ends the identification pattern, so the next pointer read returns the pointer.
- R7: `cfgChanged` is high for exactly the one cycle after each accepted data write, including a write of an unchanged value. The three bytes change only in such a cycle.
- R8: Once bit 6 of the power/test byte is 1, data writes are refused (no byte change, no pulse) until reset. Pointer writes and all reads still work.
- R9: With `busRd` low, `busRdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| strap | input | 5 | Selects the reset contents of the three bytes |
| busAddr | input | 16 | I/O address |
| busWr | input | 1 | Single-cycle write strobe |
| busRd | input | 1 | Single-cycle read strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, valid while busRd is high |
| enableReg | output | 8 | Function-enable byte |
| addrReg | output | 8 | Function-address byte |
| powerReg | output | 8 | Power/test byte, bit 6 is the lock |
| cfgChanged | output | 1 | One-cycle pulse after a configuration byte write |

## Verification
A wrong pointer shows on the very next data read as the wrong byte, or as 0x00 where a byte was expected. It also shows on a data write, which then lands on the wrong output bus in the following cycle. A wrong identification step counter shows on the next pointer read, which returns 0x88 or 0x00 in place of the pointer or the other way round. A wrong lock state shows at the first data write after the lock bit changes: either a byte moves and `cfgChanged` pulses when it should stay still, or the reverse.

// File: rtl/sioCfgPkg.sv
package sioCfgPkg;

  localparam int REG_COUNT = 3;
  localparam int LOCK_BIT  = 6;
  localparam logic [7:0] ID_FIRST  = 8'h88;
  localparam logic [7:0] ID_SECOND = 8'h00;

  // Strobes from control to datapath
  typedef struct packed {
    logic                 wrIndex;
    logic [REG_COUNT-1:0] wrReg;
    logic                 rdIndex;
    logic                 rdData;
  } ctlStrobes_t;

  function automatic logic [7:0] enableDefault(input logic [4:0] s);
    logic [7:0] v;
    if (s <= 5'd5)       v = 8'h4F;
    else if (s <= 5'd11) v = 8'h4B;
    else if (s <= 5'd15) v = 8'h0F;
    else if (s <= 5'd19) v = 8'h49;
    else if (s <= 5'd23) v = 8'h07;
    else if (s <= 5'd29) v = 8'h47;
    else if (s == 5'd30) v = 8'h08;
    else                 v = 8'h00;
    return v;
  endfunction

  function automatic logic [7:0] addrDefault(input logic [4:0] s);
    logic [7:0] v;
    case (s)
      5'd0, 5'd12, 5'd20, 5'd24, 5'd30, 5'd31: v = 8'h10;
      5'd1, 5'd2, 5'd13, 5'd21, 5'd25, 5'd26:  v = 8'h11;
      5'd3, 5'd14, 5'd22, 5'd27:               v = 8'h39;
      5'd4, 5'd15, 5'd23, 5'd28:               v = 8'h24;
      5'd5, 5'd29:                             v = 8'h38;
      5'd7, 5'd8, 5'd17, 5'd18:                v = 8'h01;
      5'd10, 5'd11:                            v = 8'h08;
      5'd9:                                    v = 8'h09;
      default:                                 v = 8'h00;
    endcase
    return v;
  endfunction

  function automatic logic [7:0] powerDefault(input logic [4:0] s);
    return (s == 5'd31) ? 8'h02 : 8'h00;
  endfunction

endpackage

// File: rtl/sioCfgCtrl.sv
module sioCfgCtrl
  import sioCfgPkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] BASE_ADDR = 16'h0398
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [7:0]        selIndex,
  input  logic              lockBit,
  output ctlStrobes_t       strobes,
  output logic [1:0]        idStep,
  output logic              cfgChanged
);

  localparam logic [ADDR_W-1:0] BASE_W = ADDR_W'(BASE_ADDR);

  logic hit;
  logic dataSel;

  assign hit     = (busAddr[ADDR_W-1:1] == BASE_W[ADDR_W-1:1]);
  assign dataSel = busAddr[0];

  always_comb begin
    strobes.wrIndex = hit && busWr && !dataSel;
    strobes.rdIndex = hit && busRd && !busWr && !dataSel;
    strobes.rdData  = hit && busRd && dataSel;
  end

  for (genvar i = 0; i < REG_COUNT; i++) begin : g_wr
    assign strobes.wrReg[i] = hit && busWr && dataSel && !lockBit &&
                              (selIndex == 8'(i));
  end

  // Identification step: 0 and 1 give the ID bytes, 2 gives the pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idStep <= 2'd0;
    end else if (strobes.wrIndex) begin
      idStep <= 2'd2;
    end else if (strobes.rdIndex && idStep != 2'd2) begin
      idStep <= idStep + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgChanged <= 1'b0;
    else       cfgChanged <= |strobes.wrReg;
  end

  // R6
  id_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrIndex |=> (idStep == 2'd2));

  // R5
  id_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    idStep != 2'd3);

endmodule

// File: rtl/sioCfgRegs.sv
module sioCfgRegs
  import sioCfgPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [4:0]  strap,
  input  logic [7:0]  busWdata,
  input  ctlStrobes_t strobes,
  input  logic [1:0]  idStep,
  output logic [7:0]  selIndex,
  output logic [7:0]  enableReg,
  output logic [7:0]  addrReg,
  output logic [7:0]  powerReg,
  output logic [7:0]  busRdata
);

  logic [7:0] cfgRegs [REG_COUNT];
  logic [7:0] resetVals [REG_COUNT];

  assign resetVals[0] = enableDefault(strap);
  assign resetVals[1] = addrDefault(strap);
  assign resetVals[2] = powerDefault(strap);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 selIndex <= 8'd0;
    else if (strobes.wrIndex)  selIndex <= busWdata;
  end

  for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 cfgRegs[i] <= resetVals[i];
      else if (strobes.wrReg[i]) cfgRegs[i] <= busWdata;
    end
  end

  assign enableReg = cfgRegs[0];
  assign addrReg   = cfgRegs[1];
  assign powerReg  = cfgRegs[2];

  always_comb begin
    busRdata = 8'h00;
    if (strobes.rdIndex) begin
      case (idStep)
        2'd0:    busRdata = ID_FIRST;
        2'd1:    busRdata = ID_SECOND;
        default: busRdata = selIndex;
      endcase
    end else if (strobes.rdData && selIndex < 8'(REG_COUNT)) begin
      busRdata = cfgRegs[selIndex[1:0]];
    end
  end

  // R8
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    powerReg[LOCK_BIT] |=> $stable({enableReg, addrReg, powerReg}));

endmodule

// File: rtl/sioCfgPort.sv
module sioCfgPort
  import sioCfgPkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] BASE_ADDR = 16'h0398
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [4:0]        strap,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  output logic [7:0]        enableReg,
  output logic [7:0]        addrReg,
  output logic [7:0]        powerReg,
  output logic              cfgChanged
);

  ctlStrobes_t strobes;
  logic [1:0]  idStep;
  logic [7:0]  selIndex;

  sioCfgCtrl #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busAddr    (busAddr),
    .busWr      (busWr),
    .busRd      (busRd),
    .selIndex   (selIndex),
    .lockBit    (powerReg[LOCK_BIT]),
    .strobes    (strobes),
    .idStep     (idStep),
    .cfgChanged (cfgChanged)
  );

  sioCfgRegs u_regs (
    .clk       (clk),
    .rstN      (rstN),
    .strap     (strap),
    .busWdata  (busWdata),
    .strobes   (strobes),
    .idStep    (idStep),
    .selIndex  (selIndex),
    .enableReg (enableReg),
    .addrReg   (addrReg),
    .powerReg  (powerReg),
    .busRdata  (busRdata)
  );

  // R7
  change_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    ({enableReg, addrReg, powerReg} != $past({enableReg, addrReg, powerReg}))
      |-> cfgChanged);

endmodule

// File: tb/sioCfgPort_test.sv
`timescale 1ns/1ps
module sioCfgPort_test;

  localparam logic [15:0] BASE = 16'h0398;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  strap = 5'd1;
  logic [15:0] busAddr = 16'h0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [7:0]  busWdata = 8'h0;
  logic [7:0]  busRdata, enableReg, addrReg, powerReg;
  logic        cfgChanged;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] mReg [3];
  logic [7:0] mIdx;
  int         mStep;

  always #4 clk = ~clk;

  sioCfgPort uut (
    .clk(clk), .rstN(rstN), .strap(strap), .busAddr(busAddr),
    .busWr(busWr), .busRd(busRd), .busWdata(busWdata), .busRdata(busRdata),
    .enableReg(enableReg), .addrReg(addrReg), .powerReg(powerReg),
    .cfgChanged(cfgChanged)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expRead(input bit rd, input logic [15:0] a);
    if (!rd || a[15:1] != BASE[15:1]) return 8'h00;
    if (a[0]) return (mIdx < 8'd3) ? mReg[mIdx[1:0]] : 8'h00;
    if (mStep == 0) return 8'h88;
    if (mStep == 1) return 8'h00;
    return mIdx;
  endfunction

  task automatic checkRegs(input string req);
    check(enableReg, mReg[0], req);
    check(addrReg,   mReg[1], req);
    check(powerReg,  mReg[2], req);
  endtask

  task automatic busOp(input bit wr, input bit rd, input logic [15:0] a,
                       input logic [7:0] d, input string req);
    bit hit;
    bit accepted;
    @(negedge clk);
    busWr = wr; busRd = rd; busAddr = a; busWdata = d;
    #1;
    hit = (a[15:1] == BASE[15:1]);
    check(busRdata, expRead(rd, a), req);
    accepted = 1'b0;
    if (wr && hit) begin
      if (!a[0]) begin
        mIdx = d; mStep = 2;
      end else if (mIdx < 8'd3 && !mReg[2][6]) begin
        mReg[mIdx[1:0]] = d; accepted = 1'b1;
      end
    end else if (rd && hit && !a[0] && mStep < 2) begin
      mStep++;
    end
    @(posedge clk); #1;
    checkRegs(req);
    check({7'd0, cfgChanged}, {7'd0, accepted}, {req, " pulse R7"});
    busWr = 1'b0; busRd = 1'b0;
  endtask

  task automatic doReset(input logic [4:0] s, input logic [7:0] e,
                         input logic [7:0] ad, input logic [7:0] p);
    @(negedge clk);
    rstN = 1'b0; strap = s;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    mReg[0] = e; mReg[1] = ad; mReg[2] = p; mIdx = 8'd0; mStep = 0;
    #1;
    checkRegs("R4 reset values");
    check({7'd0, cfgChanged}, 8'd0, "R4 no pulse");
  endtask

  initial begin
    void'($urandom(32'd5150));
    // R4 strap 31
    doReset(5'd31, 8'h00, 8'h10, 8'h02);
    busOp(0, 1, BASE + 16'd1, 8'h00, "R4 pointer 0 after reset");
    // R4 strap 1, R5 id sequence
    doReset(5'd1, 8'h4F, 8'h11, 8'h00);
    busOp(0, 0, BASE, 8'h00, "R9 idle read zero");
    busOp(0, 1, BASE, 8'h00, "R5 first id");
    busOp(0, 1, BASE, 8'h00, "R5 second id");
    busOp(0, 1, BASE, 8'h00, "R5 pointer after id");
    // R6 pointer write ends pattern right after reset
    doReset(5'd1, 8'h4F, 8'h11, 8'h00);
    busOp(1, 0, BASE, 8'h01, "R6 pointer write");
    busOp(0, 1, BASE, 8'h00, "R6 pointer read");
    busOp(0, 1, BASE + 16'd1, 8'h00, "R2 read addr byte");
    busOp(1, 0, BASE + 16'd1, 8'h5A, "R2 write addr byte");
    busOp(1, 0, BASE + 16'd1, 8'h5A, "R7 same value write");
    // R3 out-of-range pointer
    busOp(1, 0, BASE, 8'h03, "R3 pointer 3");
    busOp(1, 0, BASE + 16'd1, 8'hFF, "R3 write ignored");
    busOp(0, 1, BASE + 16'd1, 8'h00, "R3 read zero");
    busOp(1, 0, BASE, 8'hC2, "R3 pointer C2");
    busOp(0, 1, BASE, 8'h00, "R6 full byte pointer");
    // R1 misses
    busOp(1, 0, 16'h03F8, 8'h00, "R1 foreign pointer write");
    busOp(0, 1, 16'h039A, 8'h00, "R1 foreign read");
    busOp(0, 1, BASE, 8'h00, "R1 pointer kept");
    // random phase, lock bit kept clear
    for (int n = 0; n < 3000; n++) begin
      int r;
      logic [15:0] a;
      logic [7:0]  d;
      bit wr;
      r = $urandom % 8;
      a = (r < 3) ? BASE : (r < 6) ? BASE + 16'd1 : (r == 6) ? BASE + 16'd2 : 16'h03F8;
      wr = ($urandom % 2) == 1;
      d = a[0] ? (8'($urandom) & 8'hBF) : 8'($urandom % 5);
      busOp(wr, !wr, a, d, "R2 random");
    end
    // R8 lock
    busOp(1, 0, BASE, 8'h02, "R8 select power");
    busOp(1, 0, BASE + 16'd1, 8'h40, "R8 set lock");
    busOp(1, 0, BASE + 16'd1, 8'h00, "R8 blocked power");
    busOp(1, 0, BASE, 8'h00, "R8 pointer still writable");
    busOp(1, 0, BASE + 16'd1, 8'hA5, "R8 blocked enable");
    busOp(0, 1, BASE + 16'd1, 8'h00, "R8 read still works");
    doReset(5'd1, 8'h4F, 8'h11, 8'h00);
    busOp(1, 0, BASE + 16'd1, 8'h33, "R8 unlocked by reset");
    busOp(0, 0, BASE, 8'h00, "R9 idle");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule